// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake

This block receives asynchronous serial frames from a line that many nodes share, one of which talks at a time. Each block of frames starts with an address frame. Every listener sees the address frames, and the controlling logic raises a sleep input so that it hears only those. A listener whose address matches drops sleep and then receives the data frames that follow. A listener whose address does not match stays asleep, and the data frames pass it silently. The block only receives, marks which frames are addresses, and gates its status. It does not change the sleep input and does not compare addresses.

There are two ways to mark an address frame, and a mode input picks one. In address-bit mode every frame carries a ninth bit after its eight data bits, and that bit marks the frame as an address. In idle-line mode frames carry no extra bit, and a frame counts as an address when the line was quiet for a long stretch before it. Bits are timed by an external oversampling tick, 16 ticks per bit, and each bit is sampled near its middle.

Top module: `mpwake_rx`

## Requirements
- R1: A frame is a low start bit, then 8 data bits least significant first, then (in address-bit mode only) one address bit, then one stop bit. Each bit lasts 16 baud ticks and is sampled once near its middle. On an accepted frame, rx_data takes the 8 data bits.
- R2: A low pulse that has ended before the middle of the start bit is discarded. It produces no frame and does not disturb the frame that follows.
- R3: With mode_addr_bit = 1 (address-bit mode), a frame is an address when its address bit is 1 and a data frame when that bit is 0.
- R4: With mode_addr_bit = 0 (idle-line mode), a frame is an address when its start bit follows at least 10 whole bit times of high line, counted from the stop bit of the previous frame. Any start bit restarts the count, and the count saturates at 10.
- R5: With sleep = 0, every completed frame sets rx_ready, loads rx_data, sets rx_wake to 1 for an address frame and to 0 for a data frame, and sets frame_err to the inverse of the sampled stop bit.
- R6: With sleep = 1, a completed frame that is not an address leaves rx_ready, rx_wake, frame_err, rx_irq and rx_data unchanged, even when its stop bit is bad.
- R7: With sleep = 1, a completed address frame is reported exactly as in R5.
- R8: frame_err = 1 after an accepted frame whose stop bit was sampled low. After such a frame the receiver waits for the line to go high again before it looks for a new start bit.
- R9: rx_irq is 1 exactly when rx_ready is 1 and rx_int_en is 1. It is registered and follows rx_int_en one cycle later.
- R10: A one-cycle rd_strobe clears rx_ready, rx_wake and frame_err. rx_data keeps its value.
- R11: When rd_strobe and the completion of an accepted frame fall in the same cycle, the frame wins: rx_ready = 1, rx_data holds the new byte, and the new frame's wake and error values are set.
- R12: After reset, rx_data = 0 and rx_ready, rx_wake, frame_err and rx_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high, asynchronous to clk |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| mode_addr_bit | input | 1 | 1 = address-bit mode, 0 = idle-line mode |
| sleep | input | 1 | 1 = report address frames only |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the received byte; clears the flags |
| rx_data | output | 8 | Last accepted byte |
| rx_ready | output | 1 | An accepted byte is waiting |
| rx_wake | output | 1 | The last accepted frame was an address |
| frame_err | output | 1 | The last accepted frame had a low stop bit |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A frame can complete in the very cycle that the controller strobes a read. When that happens, the status logic must let the new byte win over the clear. The bench first sends a probe frame with no read, and records the exact cycle in which rx_ready rises. It then sends frames with the strobe placed one cycle before that offset, at that offset, and one cycle after it. rx_ready and rx_data are judged at the end of each stop bit: the strobe at the completion cycle and the strobe before it must both leave the new byte ready, and the strobe after it must clear rx_ready while the new byte stays in rx_data.

// File: rtl/mpwake_pkg.sv
package mpwake_pkg;

  // Receive sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ABIT,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

endpackage

// File: rtl/mpwake_sampler.sv
module mpwake_sampler
  import mpwake_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              baud_tick,
  input  logic              abit_en,
  output logic              line,
  output logic              in_idle,
  output logic              start_seen,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_abit,
  output logic              frame_stop
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

  logic              rx_meta;
  logic              rx_s;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              abit_q;
  logic              stop_q;
  logic              done_q;
  logic              start_q;

  // two-flop synchronizer; the line idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_in;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      abit_q  <= 1'b0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      if (baud_tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rx_s) begin
              state   <= ST_START;
              cnt     <= '0;
              start_q <= 1'b1;
            end
          end
          ST_START: begin
            if (cnt == CNT_MID) begin
              cnt    <= '0;
              idx    <= '0;
              abit_q <= 1'b0;
              state  <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == CNT_LAST) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              if (idx == IDX_LAST) begin
                state <= abit_en ? ST_ABIT : ST_STOP;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ABIT: begin
            if (cnt == CNT_LAST) begin
              cnt    <= '0;
              abit_q <= rx_s;
              state  <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == CNT_LAST) begin
              cnt    <= '0;
              stop_q <= rx_s;
              done_q <= 1'b1;
              state  <= rx_s ? ST_IDLE : ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_HOLD: begin
            if (rx_s) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign line       = rx_s;
  assign in_idle    = (state == ST_IDLE);
  assign start_seen = start_q;
  assign frame_done = done_q;
  assign frame_data = shreg;
  assign frame_abit = abit_q;
  assign frame_stop = stop_q;

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && baud_tick && cnt == CNT_MID && rx_s) |=> (state == ST_IDLE && !done_q)) // R2
    else $error("glitch start not dropped");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q) // R1
    else $error("frame completion longer than one cycle");

endmodule

// File: rtl/mpwake_gap.sv
module mpwake_gap #(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  input  logic count_en,
  input  logic start_seen,
  output logic gap_long
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_SAT  = BW'(IDLE_BITS);

  logic [CW-1:0] tick_cnt;
  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      bit_cnt  <= '0;
      gap_long <= 1'b0;
    end else if (start_seen) begin
      gap_long <= (bit_cnt == BIT_SAT);
      tick_cnt <= '0;
      bit_cnt  <= '0;
    end else if (baud_tick && count_en) begin
      if (tick_cnt == CNT_LAST) begin
        tick_cnt <= '0;
        if (bit_cnt != BIT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  AST_GAP_SATURATES: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BIT_SAT) // R4
    else $error("idle count past saturation");

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> (bit_cnt == '0)) // R4
    else $error("idle count not restarted by start bit");

endmodule

// File: rtl/mpwake_status.sv
module mpwake_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_abit,
  input  logic              frame_stop,
  input  logic              gap_long,
  input  logic              mode_addr_bit,
  input  logic              sleep,
  input  logic              rx_int_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_wake,
  output logic              frame_err,
  output logic              rx_irq
);

  logic              is_addr;
  logic              accept;
  logic [DATA_W-1:0] data_n;
  logic              ready_n;
  logic              wake_n;
  logic              err_n;

  always_comb begin
    is_addr = mode_addr_bit ? frame_abit : gap_long;
    accept  = frame_done && (!sleep || is_addr);
    data_n  = rx_data;
    ready_n = rx_ready;
    wake_n  = rx_wake;
    err_n   = frame_err;
    if (rd_strobe) begin
      ready_n = 1'b0;
      wake_n  = 1'b0;
      err_n   = 1'b0;
    end
    if (accept) begin
      data_n  = frame_data;
      ready_n = 1'b1;
      wake_n  = is_addr;
      err_n   = !frame_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_ready  <= 1'b0;
      rx_wake   <= 1'b0;
      frame_err <= 1'b0;
      rx_irq    <= 1'b0;
    end else begin
      rx_data   <= data_n;
      rx_ready  <= ready_n;
      rx_wake   <= wake_n;
      frame_err <= err_n;
      rx_irq    <= ready_n && rx_int_en;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> (!rx_ready && !rx_wake && !frame_err)) // R10
    else $error("read did not clear flags");

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && sleep && !is_addr && !rd_strobe) |=>
      ($stable(rx_ready) && $stable(rx_data) && $stable(frame_err) && $stable(rx_wake))) // R6
    else $error("sleeping receiver reported a data frame");

  AST_FRAME_WINS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (!sleep || is_addr)) |=> rx_ready) // R11
    else $error("accepted frame lost");

  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_ready) // R9
    else $error("interrupt without ready");

  AST_ADDR_BIT_WAKE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && mode_addr_bit && !sleep) |=> (rx_wake == $past(frame_abit))) // R3
    else $error("wake flag does not follow address bit");

endmodule

// File: rtl/mpwake_rx.sv
module mpwake_rx #(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              baud_tick,
  input  logic              mode_addr_bit,
  input  logic              sleep,
  input  logic              rx_int_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_wake,
  output logic              frame_err,
  output logic              rx_irq
);

  logic              line;
  logic              in_idle;
  logic              start_seen;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_abit;
  logic              frame_stop;
  logic              gap_long;

  mpwake_sampler #(
    .OVS    (OVS),
    .DATA_W (DATA_W)
  ) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .rx_in      (rx_in),
    .baud_tick  (baud_tick),
    .abit_en    (mode_addr_bit),
    .line       (line),
    .in_idle    (in_idle),
    .start_seen (start_seen),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .frame_abit (frame_abit),
    .frame_stop (frame_stop)
  );

  mpwake_gap #(
    .OVS       (OVS),
    .IDLE_BITS (IDLE_BITS)
  ) u_gap (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .count_en   (in_idle && line),
    .start_seen (start_seen),
    .gap_long   (gap_long)
  );

  mpwake_status #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk           (clk),
    .rst           (rst),
    .frame_done    (frame_done),
    .frame_data    (frame_data),
    .frame_abit    (frame_abit),
    .frame_stop    (frame_stop),
    .gap_long      (gap_long),
    .mode_addr_bit (mode_addr_bit),
    .sleep         (sleep),
    .rx_int_en     (rx_int_en),
    .rd_strobe     (rd_strobe),
    .rx_data       (rx_data),
    .rx_ready      (rx_ready),
    .rx_wake       (rx_wake),
    .frame_err     (frame_err),
    .rx_irq        (rx_irq)
  );

endmodule

// File: tb/mpwake_rx_bench.sv
module mpwake_rx_bench;

  localparam int BIT_CYC = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       baud_tick = 1'b0;
  logic       mode_addr_bit = 1'b1;
  logic       sleep = 1'b0;
  logic       rx_int_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       rx_wake;
  logic       frame_err;
  logic       rx_irq;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0] e_data = 8'h00;
  logic       e_rdy = 1'b0, e_wake = 1'b0, e_err = 1'b0;
  int         gap_prev = 0;
  int         o_ref = 1000;

  always #2 clk = ~clk;

  mpwake_rx u_mpwake_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .baud_tick(baud_tick),
    .mode_addr_bit(mode_addr_bit), .sleep(sleep), .rx_int_en(rx_int_en),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_wake(rx_wake), .frame_err(frame_err), .rx_irq(rx_irq)
  );

  function automatic logic exp_addr(input logic m, input logic ab, input int gap);
    return m ? ab : (gap >= 10);
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    baud_tick = cyc[0];
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "rx_data",   int'(rx_data),   int'(e_data));
    chk(tag, "rx_ready",  int'(rx_ready),  int'(e_rdy));
    chk(tag, "rx_wake",   int'(rx_wake),   int'(e_wake));
    chk(tag, "frame_err", int'(frame_err), int'(e_err));
    chk(tag, "rx_irq",    int'(rx_irq),    int'(e_rdy & rx_int_en));
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (BIT_CYC) step();
  endtask

  task automatic send(input logic [7:0] d, input logic ab, input logic stp,
                      input int rd_at, output int rise);
    rise = -1;
    while (cyc[0] != 1'b0) step();
    drive_bit(1'b0);
    for (int b = 0; b < 8; b++) drive_bit(d[b]);
    if (mode_addr_bit) drive_bit(ab);
    rx_in = stp;
    for (int i = 0; i < BIT_CYC; i++) begin
      rd_strobe = (i == rd_at);
      step();
      if (rise < 0 && rx_ready) rise = i;
    end
    rd_strobe = 1'b0;
    rx_in = 1'b1;
  endtask

  task automatic do_frame(input logic m, input logic s, input logic e,
                          input logic [7:0] d, input logic ab, input logic stp,
                          input int rd_at, input int g, input string tag,
                          output int rise);
    logic a;
    mode_addr_bit = m;
    sleep = s;
    rx_int_en = e;
    send(d, ab, stp, rd_at, rise);
    a = exp_addr(m, ab, gap_prev);
    if (!s || a) begin
      e_rdy = 1'b1; e_wake = a; e_err = !stp; e_data = d;
    end
    if (rd_at >= 0 && rd_at > o_ref) begin
      e_rdy = 1'b0; e_wake = 1'b0; e_err = 1'b0;
    end
    check_all(tag);
    repeat (g * BIT_CYC) step();
    gap_prev = g;
  endtask

  task automatic do_read(input string tag);
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
    step();
    e_rdy = 1'b0; e_wake = 1'b0; e_err = 1'b0;
    check_all(tag);
  endtask

  initial begin
    int r;
    int gaps [8] = '{1, 2, 4, 9, 10, 11, 13, 3};
    void'($urandom(32'h5EED));
    repeat (5) step();
    check_all("R12 reset");
    rst = 1'b0;
    repeat (12 * BIT_CYC) step();
    gap_prev = 12;

    // R1 R3 R5 R9: data frame in address-bit mode, awake
    do_frame(1, 0, 1, 8'hA5, 0, 1, -1, 3, "R1/R3/R5/R9 data frame", r);
    do_read("R10 read clears");
    // R3 R5: address frame awake
    do_frame(1, 0, 1, 8'h5A, 1, 1, -1, 3, "R3/R5 address frame", r);
    do_read("R10 read clears");
    // R6 R7: sleeping, data then address
    do_frame(1, 1, 1, 8'h11, 0, 1, -1, 3, "R6 sleep hides data", r);
    do_frame(1, 1, 1, 8'h3C, 1, 1, -1, 3, "R7 sleep passes address", r);
    do_read("R10 read clears");
    // R6 R8: bad stop while asleep, data then address
    do_frame(1, 1, 1, 8'hF0, 0, 0, -1, 12, "R6 sleep hides bad data", r);
    do_frame(1, 1, 1, 8'h0F, 1, 0, -1, 12, "R8 framing error on address", r);
    do_read("R10 read clears error");
    // R4: idle-line mode gap boundary
    do_frame(0, 0, 1, 8'h42, 0, 1, -1, 9, "R4/R5 idle mode after long gap", r);
    do_read("R10 read");
    do_frame(0, 1, 1, 8'h43, 0, 1, -1, 10, "R4/R6 gap 9 is data", r);
    do_frame(0, 1, 1, 8'h44, 0, 1, -1, 12, "R4/R7 gap 10 is address", r);
    // R9: interrupt disabled
    do_frame(1, 0, 0, 8'h99, 0, 1, -1, 3, "R9 irq masked", r);
    rx_int_en = 1'b1;
    step(); step();
    check_all("R9 irq follows enable");
    do_read("R10 read");

    // R2: short low pulse rejected
    mode_addr_bit = 1; sleep = 0;
    while (cyc[0] != 1'b0) step();
    rx_in = 1'b0;
    repeat (6) step();
    rx_in = 1'b1;
    repeat (16 * BIT_CYC) step();
    check_all("R2 glitch ignored");
    gap_prev = 16;
    do_frame(1, 0, 1, 8'h81, 0, 1, -1, 3, "R2 frame after glitch", r);

    // R11: read strobe against frame completion
    do_read("R10 read");
    do_frame(1, 0, 1, 8'h55, 0, 1, -1, 3, "R11 probe", r);
    if (r < 1) begin
      vectors++; fails++;
      $display("FAIL R11 probe rise offset: actual %0d expected >0", r);
    end else begin
      o_ref = r;
      do_frame(1, 0, 1, 8'h66, 0, 1, o_ref,     3, "R11 same-cycle read", r);
      do_frame(1, 0, 1, 8'h67, 0, 1, o_ref - 1, 3, "R11 read one before", r);
      do_frame(1, 0, 1, 8'h77, 0, 1, o_ref + 1, 3, "R11/R10 read one after", r);
    end

    // random traffic
    for (int n = 0; n < 60; n++) begin
      do_frame(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
               1'($urandom_range(0, 1)), 1'b1, -1,
               gaps[$urandom_range(0, 7)], "R1/R3/R4/R5/R6/R7/R9 random", r);
      if ($urandom_range(0, 2) == 0) do_read("R10 random read");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule